// File: doc/BRIEF.md
# External Bus Sequencer for an 8-bit Microcontroller

This block produces the multiplexed external memory bus timing for an 8-bit controller core with a 16-bit address space. Time is divided into slots, and each slot begins with a one-clock address latch strobe. A slot is 6 oscillator clocks long in normal mode and 3 clocks long in double-speed mode. Two slots make one machine cycle. In each slot the core may ask for a code fetch at a program counter value. At the start of a machine cycle it may instead ask for a data-memory access. Such an access carries an address, a wide/narrow address flag, a direction, write data and the current value of the high port register.

For each fetch the block decides whether the code lives in internal memory or on the external bus. The decision uses the internal-code enable input, which can be frozen at reset by the lock option. An external fetch drives the address, asserts the program read strobe and captures the returned byte. A data access takes the whole machine cycle. It issues one address strobe, holds the data read or write strobe across both slots, and issues no program reads. The low byte is multiplexed: it carries the address while the latch strobe is high, then the write data, or it is released for reads. The high byte carries either the upper address bits or the high port register value. A quiet option keeps the latch strobe low in every slot that does not go to the bus.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst` is high (sampled at a clock edge), `addr_stb`=0, `prog_rd_n`=1, `dat_rd_n`=1, `dat_wr_n`=1 and `ad_oe`=0. After `rst` falls, the first slot starts on the next clock, as half 0 of a machine cycle.
- R2: With `stb_quiet`=0 and no data access, `addr_stb` is high for exactly one clock in every slot. Consecutive pulses are P clocks apart, where P=6 when `fast_mode`=0 and P=3 when `fast_mode`=1. `fast_mode` is sampled at each slot start.
- R3: An external fetch slot drives `prog_rd_n` low for P-2 consecutive clocks, from slot phase 1 to phase P-2. Back-to-back external fetches therefore give two program read strobes per machine cycle of 2P clocks.
- R4: A machine cycle used for a data access has exactly one `addr_stb` pulse, in phase 0 of half 0, and `prog_rd_n` stays high for the whole cycle. The data strobe (`dat_rd_n` when `dwr`=0, `dat_wr_n` when `dwr`=1) is low for 2P-2 clocks, from half 0 phase 1 to half 1 phase P-2.
- R5: A fetch is internal, with `prog_rd_n` held high, when the effective internal-code enable is 1 and `fetch_pc` <= 0x1FFF. It is external when `fetch_pc` >= 0x2000 or when the enable is 0.
- R6: With `stb_quiet`=1, `addr_stb` pulses only in external fetch slots and in the first slot of a data access. It stays low in internal-fetch and idle slots.
- R7: `a_hi` equals `fetch_pc[15:8]` during an external fetch, and `daddr[15:8]` during a data access with `dwide`=1. During a data access with `dwide`=0 it equals `p2_val`. Each value is latched at slot start.
- R8: While `addr_stb` is high in an external slot, `ad_oe`=1 and `ad_out` is the low address byte. During a write cycle `ad_oe`=1 and `ad_out`=`dwdata` for the rest of the machine cycle. During a read cycle `ad_oe`=0 for the rest of the cycle.
- R9: `ad_in` is captured on the clock edge where the program or data read strobe rises. `cap_vld` is high for one clock after that edge, with the byte in `cap_byte`.
- R10: When `ie_lock`=1, the effective internal-code enable is the value `int_code_en` had during reset, and later changes to the input are ignored. When `ie_lock`=0 the live input is used.
- R11: `dat_done` pulses for one clock in the last clock of every data access machine cycle, which is half 1, phase P-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1 selects 3-clock slots, 0 selects 6-clock slots |
| stb_quiet | input | 1 | Suppress the address strobe in slots that do not use the bus |
| int_code_en | input | 1 | Internal-code enable; 1 allows fetches at or below 0x1FFF to stay internal |
| ie_lock | input | 1 | Freeze the internal-code enable at its reset value |
| fetch_req | input | 1 | Core requests a code fetch in the next slot |
| fetch_pc | input | 16 | Program counter of the requested fetch |
| dreq | input | 1 | Data access request, taken at a machine-cycle start; hold until `dat_done` |
| dwide | input | 1 | 1 = 16-bit data address, 0 = 8-bit data address |
| dwr | input | 1 | 1 = data write, 0 = data read |
| daddr | input | 16 | Data address |
| dwdata | input | 8 | Write data |
| p2_val | input | 8 | Current high port register contents |
| ad_in | input | 8 | Low bus input from the pads |
| addr_stb | output | 1 | Address latch strobe, active high |
| prog_rd_n | output | 1 | Program read strobe, active low |
| dat_rd_n | output | 1 | Data read strobe, active low |
| dat_wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low bus output value |
| ad_oe | output | 1 | Low bus output enable |
| a_hi | output | 8 | High address byte |
| cap_byte | output | 8 | Byte captured at the last read strobe rise |
| cap_vld | output | 1 | One-clock pulse marking a new `cap_byte` |
| dat_done | output | 1 | One-clock pulse at the end of a data access |

## Verification
If the slot phase counter drifts, the address strobe spacing breaks within one slot: the pulse lands early or late relative to the P-clock grid, and that shows up as a wrong gap or a wrong pulse count in a window of eight slots. If the slot kind is latched wrongly at a machine-cycle boundary, the error appears in the very next slot. That slot shows an extra address strobe or program read inside a data access, a data strobe that is two clocks short, or a high byte taken from the wrong source. If the internal-code decision or the lock latch holds a wrong value, program read strobes appear or vanish from the first fetch slot after the change. Both speed modes are covered.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   // kind of work assigned to one slot, decided at the slot start
   typedef enum logic [2:0] {
      SK_IDLE = 3'd0,
      SK_FINT = 3'd1,
      SK_FEXT = 3'd2,
      SK_DRD  = 3'd3,
      SK_DWR  = 3'd4
   } slot_kind_t;

   function automatic logic is_data(input slot_kind_t k);
      return (k == SK_DRD) || (k == SK_DWR);
   endfunction

endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
   parameter int NORM_CLKS = 6,
   parameter int FAST_CLKS = 3,
   parameter int PH_W      = $clog2(NORM_CLKS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fast_mode,
   output logic [PH_W-1:0] ph,
   output logic            half,
   output logic [PH_W-1:0] last,
   output logic            live,
   output logic            load,
   output logic            nxt_half
);

   localparam logic [PH_W-1:0] NORM_LAST = PH_W'(NORM_CLKS - 1);
   localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_CLKS - 1);

   generate
      if (FAST_CLKS < 3) begin : g_bad_fast
         $error("xbus_timebase: FAST_CLKS must be at least 3");
      end
      if (NORM_CLKS < FAST_CLKS) begin : g_bad_norm
         $error("xbus_timebase: NORM_CLKS must not be below FAST_CLKS");
      end
   endgenerate

   logic fast_q;

   always_comb begin
      last     = fast_q ? FAST_LAST : NORM_LAST;
      load     = !live || (ph == last);
      nxt_half = live ? ~half : 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live   <= 1'b0;
         ph     <= '0;
         half   <= 1'b0;
         fast_q <= 1'b0;
      end else begin
         live <= 1'b1;
         if (load) begin
            ph     <= '0;
            half   <= nxt_half;
            fast_q <= fast_mode;
         end else begin
            ph <= ph + PH_W'(1);
         end
      end
   end

endmodule

// File: rtl/xbus_slot_ctl.sv
module xbus_slot_ctl
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int HI_W    = ADDR_W - DATA_W,
   parameter int INT_TOP = 'h1FFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              nxt_half,
   input  logic              int_code_en,
   input  logic              ie_lock,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              dreq,
   input  logic              dwide,
   input  logic              dwr,
   input  logic [ADDR_W-1:0] daddr,
   input  logic [DATA_W-1:0] dwdata,
   input  logic [HI_W-1:0]   p2_val,
   output slot_kind_t        kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdat_q,
   output logic [HI_W-1:0]   hi_q
);

   generate
      if (ADDR_W != DATA_W + HI_W) begin : g_bad_split
         $error("xbus_slot_ctl: ADDR_W must equal DATA_W + HI_W");
      end
   endgenerate

   // internal code range: either the whole space or a compare against the top
   logic in_int;
   generate
      if (INT_TOP >= (2 ** ADDR_W) - 1) begin : g_all_int
         assign in_int = 1'b1;
      end else begin : g_cmp
         assign in_int = (fetch_pc <= ADDR_W'(INT_TOP));
      end
   endgenerate

   // enable value frozen while reset is applied
   logic ea_hold;
   logic ea_eff;

   always_ff @(posedge clk) begin
      if (rst) ea_hold <= int_code_en;
   end

   assign ea_eff = ie_lock ? ea_hold : int_code_en;

   slot_kind_t        nk;
   logic [ADDR_W-1:0] n_addr;
   logic [DATA_W-1:0] n_wd;
   logic [HI_W-1:0]   n_hi;

   always_comb begin
      nk     = kind_q;
      n_addr = addr_q;
      n_wd   = wdat_q;
      n_hi   = hi_q;
      if (load) begin
         if (!nxt_half && dreq) begin
            nk     = dwr ? SK_DWR : SK_DRD;
            n_addr = daddr;
            n_wd   = dwdata;
            n_hi   = dwide ? daddr[ADDR_W-1:DATA_W] : p2_val;
         end else if (!(nxt_half && is_data(kind_q))) begin
            if (fetch_req) begin
               n_addr = fetch_pc;
               if (ea_eff && in_int) begin
                  nk   = SK_FINT;
                  n_hi = p2_val;
               end else begin
                  nk   = SK_FEXT;
                  n_hi = fetch_pc[ADDR_W-1:DATA_W];
               end
            end else begin
               nk   = SK_IDLE;
               n_hi = p2_val;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q <= SK_IDLE;
         addr_q <= '0;
         wdat_q <= '0;
         hi_q   <= '0;
      end else begin
         kind_q <= nk;
         addr_q <= n_addr;
         wdat_q <= n_wd;
         hi_q   <= n_hi;
      end
   end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
   import xbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HI_W   = 8,
   parameter int PH_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              live,
   input  logic [PH_W-1:0]   ph,
   input  logic              half,
   input  logic [PH_W-1:0]   last,
   input  slot_kind_t        kind,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wdat,
   input  logic [HI_W-1:0]   hi_in,
   input  logic              stb_quiet,
   input  logic [DATA_W-1:0] ad_in,
   output logic              addr_stb,
   output logic              prog_rd_n,
   output logic              dat_rd_n,
   output logic              dat_wr_n,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   a_hi,
   output logic [DATA_W-1:0] cap_byte,
   output logic              cap_vld,
   output logic              dat_done
);

   logic [PH_W-1:0] pen;
   logic            first_ph;
   logic            data_k;
   logic            ext_slot;
   logic            dstb;

   always_comb begin
      pen      = last - PH_W'(1);
      first_ph = (ph == '0);
      data_k   = is_data(kind);
      ext_slot = (kind == SK_FEXT) || (data_k && !half);
      // data strobe spans half 0 phase 1 through half 1 phase P-2
      dstb     = data_k && !(!half && first_ph) && !(half && ph == last);

      addr_stb  = live && first_ph && !(data_k && half) && (ext_slot || !stb_quiet);
      prog_rd_n = !(live && kind == SK_FEXT && !first_ph && ph != last);
      dat_rd_n  = !(live && dstb && kind == SK_DRD);
      dat_wr_n  = !(live && dstb && kind == SK_DWR);

      ad_oe  = live && ((first_ph && ext_slot) || kind == SK_DWR);
      ad_out = (kind == SK_DWR && !(!half && first_ph)) ? wdat : addr_lo;
      a_hi   = hi_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_byte <= '0;
         cap_vld  <= 1'b0;
         dat_done <= 1'b0;
      end else begin
         cap_vld  <= 1'b0;
         dat_done <= 1'b0;
         if (live && kind == SK_FEXT && ph == pen) begin
            cap_byte <= ad_in;
            cap_vld  <= 1'b1;
         end
         if (live && data_k && half && ph == pen) begin
            dat_done <= 1'b1;
            if (kind == SK_DRD) begin
               cap_byte <= ad_in;
               cap_vld  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int NORM_CLKS = 6,
   parameter int FAST_CLKS = 3,
   parameter int INT_TOP   = 'h1FFF
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     fast_mode,
   input  logic                     stb_quiet,
   input  logic                     int_code_en,
   input  logic                     ie_lock,
   input  logic                     fetch_req,
   input  logic [ADDR_W-1:0]        fetch_pc,
   input  logic                     dreq,
   input  logic                     dwide,
   input  logic                     dwr,
   input  logic [ADDR_W-1:0]        daddr,
   input  logic [DATA_W-1:0]        dwdata,
   input  logic [ADDR_W-DATA_W-1:0] p2_val,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     addr_stb,
   output logic                     prog_rd_n,
   output logic                     dat_rd_n,
   output logic                     dat_wr_n,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic [DATA_W-1:0]        cap_byte,
   output logic                     cap_vld,
   output logic                     dat_done
);

   localparam int HI_W = ADDR_W - DATA_W;
   localparam int PH_W = $clog2(NORM_CLKS);

   logic [PH_W-1:0]   ph;
   logic [PH_W-1:0]   last;
   logic              half;
   logic              live;
   logic              load;
   logic              nxt_half;
   slot_kind_t        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q;
   logic [HI_W-1:0]   hi_q;

   xbus_timebase #(
      .NORM_CLKS (NORM_CLKS),
      .FAST_CLKS (FAST_CLKS),
      .PH_W      (PH_W)
   ) u_tb (
      .clk       (clk),
      .rst       (rst),
      .fast_mode (fast_mode),
      .ph        (ph),
      .half      (half),
      .last      (last),
      .live      (live),
      .load      (load),
      .nxt_half  (nxt_half)
   );

   xbus_slot_ctl #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .HI_W    (HI_W),
      .INT_TOP (INT_TOP)
   ) u_ctl (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .nxt_half    (nxt_half),
      .int_code_en (int_code_en),
      .ie_lock     (ie_lock),
      .fetch_req   (fetch_req),
      .fetch_pc    (fetch_pc),
      .dreq        (dreq),
      .dwide       (dwide),
      .dwr         (dwr),
      .daddr       (daddr),
      .dwdata      (dwdata),
      .p2_val      (p2_val),
      .kind_q      (kind_q),
      .addr_q      (addr_q),
      .wdat_q      (wdat_q),
      .hi_q        (hi_q)
   );

   xbus_strobe_dec #(
      .DATA_W (DATA_W),
      .HI_W   (HI_W),
      .PH_W   (PH_W)
   ) u_dec (
      .clk       (clk),
      .rst       (rst),
      .live      (live),
      .ph        (ph),
      .half      (half),
      .last      (last),
      .kind      (kind_q),
      .addr_lo   (addr_q[DATA_W-1:0]),
      .wdat      (wdat_q),
      .hi_in     (hi_q),
      .stb_quiet (stb_quiet),
      .ad_in     (ad_in),
      .addr_stb  (addr_stb),
      .prog_rd_n (prog_rd_n),
      .dat_rd_n  (dat_rd_n),
      .dat_wr_n  (dat_wr_n),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .a_hi      (a_hi),
      .cap_byte  (cap_byte),
      .cap_vld   (cap_vld),
      .dat_done  (dat_done)
   );

endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk (
   input logic clk,
   input logic rst,
   input logic addr_stb,
   input logic prog_rd_n,
   input logic dat_rd_n,
   input logic dat_wr_n,
   input logic ad_oe,
   input logic cap_vld,
   input logic dat_done
);

   logic rst_q = 1'b0;

   always_ff @(posedge clk) rst_q <= rst;

   // R1: strobes idle once reset has been seen at an edge
   always @(negedge clk) begin
      if (rst && rst_q) begin
         assert_reset_idle_R1: assert (!addr_stb && prog_rd_n && dat_rd_n && dat_wr_n && !ad_oe)
            else $error("reset state not idle");
      end
   end

   assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
      addr_stb |=> !addr_stb);

   assert_prog_vs_data_R4: assert property (@(posedge clk) disable iff (rst)
      !(!prog_rd_n && (!dat_rd_n || !dat_wr_n)));

   assert_no_latch_in_data_R4: assert property (@(posedge clk) disable iff (rst)
      (!dat_rd_n || !dat_wr_n) |-> !addr_stb);

   assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(!dat_rd_n && !dat_wr_n));

   assert_bus_free_on_read_R8: assert property (@(posedge clk) disable iff (rst)
      !dat_rd_n |-> !ad_oe);

   assert_bus_driven_on_write_R8: assert property (@(posedge clk) disable iff (rst)
      !dat_wr_n |-> ad_oe);

   assert_cap_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
      cap_vld |-> (prog_rd_n && dat_rd_n && $past(!prog_rd_n || !dat_rd_n)));

   assert_done_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
      dat_done |-> $past(!dat_rd_n || !dat_wr_n));

endmodule

bind xbus_sequencer xbus_sequencer_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .addr_stb  (addr_stb),
   .prog_rd_n (prog_rd_n),
   .dat_rd_n  (dat_rd_n),
   .dat_wr_n  (dat_wr_n),
   .ad_oe     (ad_oe),
   .cap_vld   (cap_vld),
   .dat_done  (dat_done)
);

// File: tb/xbus_sequencer_tb.sv
`timescale 1ns/1ps
module xbus_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fast_mode = 1'b0;
   logic        stb_quiet = 1'b0;
   logic        int_code_en = 1'b1;
   logic        ie_lock = 1'b0;
   logic        fetch_req = 1'b1;
   logic [15:0] fetch_pc = 16'h0000;
   logic        dreq = 1'b0;
   logic        dwide = 1'b0;
   logic        dwr = 1'b0;
   logic [15:0] daddr = 16'h0000;
   logic [7:0]  dwdata = 8'h00;
   logic [7:0]  p2_val = 8'h00;
   logic [7:0]  ad_in = 8'h00;
   logic        addr_stb, prog_rd_n, dat_rd_n, dat_wr_n, ad_oe, cap_vld, dat_done;
   logic [7:0]  ad_out, a_hi, cap_byte;

   int checks = 0;
   int errors = 0;
   bit done_all = 1'b0;

   always #2.5 clk = ~clk;

   xbus_sequencer u_dut (
      .clk(clk), .rst(rst), .fast_mode(fast_mode), .stb_quiet(stb_quiet),
      .int_code_en(int_code_en), .ie_lock(ie_lock), .fetch_req(fetch_req),
      .fetch_pc(fetch_pc), .dreq(dreq), .dwide(dwide), .dwr(dwr), .daddr(daddr),
      .dwdata(dwdata), .p2_val(p2_val), .ad_in(ad_in), .addr_stb(addr_stb),
      .prog_rd_n(prog_rd_n), .dat_rd_n(dat_rd_n), .dat_wr_n(dat_wr_n),
      .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .cap_byte(cap_byte),
      .cap_vld(cap_vld), .dat_done(dat_done)
   );

   // row: [26] fast, [25] int_code_en, [24] quiet, [23:8] pc, [7:4] strobes, [3:0] prog reads
   localparam int NV = 8;
   localparam logic [26:0] VEC [0:NV-1] = '{
      {1'b0, 1'b1, 1'b0, 16'h0100, 4'd8, 4'd0},
      {1'b0, 1'b1, 1'b0, 16'h2000, 4'd8, 4'd8},
      {1'b0, 1'b0, 1'b0, 16'h0100, 4'd8, 4'd8},
      {1'b1, 1'b1, 1'b0, 16'h1FFF, 4'd8, 4'd0},
      {1'b1, 1'b1, 1'b1, 16'h1FFF, 4'd0, 4'd0},
      {1'b1, 1'b0, 1'b1, 16'h0010, 4'd8, 4'd8},
      {1'b0, 1'b1, 1'b1, 16'hFFFF, 4'd8, 4'd8},
      {1'b0, 1'b1, 1'b1, 16'h1FFF, 4'd0, 4'd0}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle outputs {stb,prd_n,drd_n,dwr_n,oe}",
          int'({addr_stb, prog_rd_n, dat_rd_n, dat_wr_n, ad_oe}), int'(5'b01110));
      rst = 1'b0;
   endtask

   task automatic count_win(input int n, input logic [7:0] hi_exp,
                            output int na, output int nfall, output int nlow, output int hibad);
      bit prev;
      na = 0; nfall = 0; nlow = 0; hibad = 0;
      prev = prog_rd_n;
      repeat (n) begin
         @(negedge clk);
         if (addr_stb) na++;
         if (!prog_rd_n) begin
            nlow++;
            if (prev) nfall++;
            if (a_hi != hi_exp) hibad++;
         end
         prev = prog_rd_n;
      end
   endtask

   task automatic stb_gap(output int g);
      int guard = 0;
      g = 0;
      while (!addr_stb && guard < 40) begin @(negedge clk); guard++; end
      do begin
         @(negedge clk);
         g++;
      end while (!addr_stb && g < 40);
   endtask

   task automatic data_cycle(input bit wr, input bit wide, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] p2,
                             input logic [7:0] busv, input int p, input string tag);
      bit pa = 1'b0;
      bit oe_ale = 1'b0;
      logic [7:0] ad_ale = 8'h00;
      logic [7:0] hi_exp;
      int guard = 0;
      int na = 0, nps = 0, nstb = 0, hibad = 0, busbad = 0;
      bit seen_done = 1'b0, capv = 1'b0;
      logic [7:0] capb = 8'h00;
      hi_exp = wide ? a[15:8] : p2;
      dreq = 1'b1; dwr = wr; dwide = wide; daddr = a; dwdata = wd; p2_val = p2; ad_in = busv;
      forever begin
         @(negedge clk);
         if (!dat_rd_n || !dat_wr_n || guard > 100) break;
         pa = addr_stb;
         if (addr_stb) begin ad_ale = ad_out; oe_ale = ad_oe; end
         guard++;
      end
      for (int k = 0; k < 2 * p - 1; k++) begin
         if (k != 0) @(negedge clk);
         if (addr_stb) na++;
         if (!prog_rd_n) nps++;
         if (!dat_rd_n || !dat_wr_n) nstb++;
         if (a_hi != hi_exp) hibad++;
         if (wr) begin
            if (!ad_oe || ad_out != wd) busbad++;
         end else if (ad_oe) busbad++;
         if (dat_done) begin
            seen_done = 1'b1; capv = cap_vld; capb = cap_byte; dreq = 1'b0;
         end
      end
      dreq = 1'b0;
      chk("R4", {tag, " strobe before data strobe"}, int'(pa), 1);
      chk("R4", {tag, " extra strobes in cycle"}, na, 0);
      chk("R4", {tag, " program reads in data cycle"}, nps, 0);
      chk("R4", {tag, " data strobe low clocks"}, nstb, 2 * p - 2);
      chk("R7", {tag, " high byte mismatches"}, hibad, 0);
      chk("R8", {tag, " address on low bus at strobe"}, int'({oe_ale, ad_ale}), int'({1'b1, a[7:0]}));
      chk("R8", {tag, " low bus drive mismatches"}, busbad, 0);
      chk("R11", {tag, " done pulse"}, int'(seen_done), 1);
      if (!wr) chk("R9", {tag, " read capture"}, int'({capv, capb}), int'({1'b1, busv}));
   endtask

   initial begin
      int na, nfall, nlow, hibad, g, p;
      logic [26:0] row;
      // table of fetch configurations
      for (int i = 0; i < NV; i++) begin
         row = VEC[i];
         fast_mode = row[26]; int_code_en = row[25]; stb_quiet = row[24];
         fetch_pc = row[23:8]; fetch_req = 1'b1; ie_lock = 1'b0; dreq = 1'b0;
         p = fast_mode ? 3 : 6;
         do_reset();
         repeat (2 * p) @(negedge clk);
         count_win(8 * p, fetch_pc[15:8], na, nfall, nlow, hibad);
         chk(stb_quiet ? "R6" : "R2", $sformatf("row %0d strobes in 8 slots", i), na, int'(row[7:4]));
         chk("R5", $sformatf("row %0d program reads in 8 slots", i), nfall, int'(row[3:0]));
         chk("R3", $sformatf("row %0d program read low clocks", i), nlow, int'(row[3:0]) * (p - 2));
         chk("R7", $sformatf("row %0d fetch high byte mismatches", i), hibad, 0);
         if (!stb_quiet) begin
            stb_gap(g);
            chk("R2", $sformatf("row %0d strobe spacing", i), g, p);
         end
      end

      // idle slots with and without the quiet option
      fast_mode = 1'b0; fetch_req = 1'b0; stb_quiet = 1'b0; int_code_en = 1'b0;
      do_reset();
      repeat (12) @(negedge clk);
      count_win(48, 8'h00, na, nfall, nlow, hibad);
      chk("R2", "idle strobes in 8 slots", na, 8);
      chk("R5", "idle program reads", nfall, 0);
      stb_quiet = 1'b1;
      repeat (12) @(negedge clk);
      count_win(48, 8'h00, na, nfall, nlow, hibad);
      chk("R6", "quiet idle strobes", na, 0);

      // code capture on an external fetch
      stb_quiet = 1'b0; fetch_req = 1'b1; fetch_pc = 16'h4321; ad_in = 8'h5A;
      do_reset();
      begin
         int guard = 0;
         do begin @(negedge clk); guard++; end while (!cap_vld && guard < 40);
      end
      chk("R9", "code byte captured", int'({cap_vld, prog_rd_n, cap_byte}), int'({2'b11, 8'h5A}));

      // data cycles, normal speed, external fetch around them
      data_cycle(1'b0, 1'b1, 16'h8A12, 8'h00, 8'h3C, 8'hC3, 6, "rd wide");
      data_cycle(1'b1, 1'b0, 16'h0077, 8'h9E, 8'h3C, 8'h00, 6, "wr narrow");
      data_cycle(1'b0, 1'b0, 16'h00F0, 8'h00, 8'hB1, 8'h2D, 6, "rd narrow");
      // data cycle, double speed
      fast_mode = 1'b1;
      do_reset();
      repeat (4) @(negedge clk);
      data_cycle(1'b1, 1'b1, 16'hC455, 8'h61, 8'h00, 8'h00, 3, "fast wr wide");

      // lock option: enable frozen at reset
      fast_mode = 1'b0; ie_lock = 1'b1; int_code_en = 1'b1; fetch_pc = 16'h0100;
      do_reset();
      int_code_en = 1'b0;
      repeat (12) @(negedge clk);
      count_win(48, 8'h01, na, nfall, nlow, hibad);
      chk("R10", "locked enable keeps fetch internal", nfall, 0);
      ie_lock = 1'b0;
      repeat (12) @(negedge clk);
      count_win(48, 8'h01, na, nfall, nlow, hibad);
      chk("R10", "unlocked enable follows input", nfall, 8);
      chk("R7", "fetch high byte after unlock", hibad, 0);

      done_all = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_all) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule